// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings so that most memory accesses are translated without a page-table walk. Pages are 4 KiB: the low 12 bits of an address pass straight through and only the upper bits, the virtual page number, are translated. Every lookup compares the page number against all stored entries at the same time and also checks the access against the permission bits kept with the matching entry. The result comes back in the same cycle as the request.

When no entry matches, the buffer stops taking new lookups and sends the page number to an external table walker over a valid/ready request and a one-cycle response. The returned mapping is written over a victim entry. Empty entries are used first. Once every entry is in use, a round-robin pointer picks the victim, so the oldest installed mapping goes first. The requester keeps its lookup asserted, and the lookup hits as soon as the buffer is ready again. A flush input empties the whole buffer in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `lk_ready` is high, `walk_req_valid` is low, and no entry is valid, so the first lookup of any page misses.
- R2: A lookup that matches a valid entry and passes the permission check sets `rsp_hit` in the same cycle, with `rsp_paddr` = {stored physical page, `lk_vaddr[11:0]`}. Any offset within the page gives the same page.
- R3: A lookup that matches no valid entry drops `lk_ready` in the next cycle and raises `walk_req_valid` with `walk_req_vpn` = `lk_vaddr[VA_W-1:12]`. Both stay stable until `walk_req_ready` accepts the request.
- R4: When `walk_rsp_valid` arrives after an accepted request, the mapping is installed and `lk_ready` rises in the next cycle. The held lookup then hits, or faults, against the new entry.
- R5: Permission bit 0 allows writes and bit 1 allows user-mode access. A matching lookup with `lk_write`=1 and bit 0 clear, or with `lk_user`=1 and bit 1 clear, sets `rsp_fault` instead of `rsp_hit` and starts no walk.
- R6: `rsp_hit` and `rsp_fault` are never high together. A lookup that hits or faults starts no walk.
- R7: Refills use empty entries first, so ENTRIES distinct pages can be held at once. When the buffer is full, refills replace entries in installation order: each refill evicts the oldest remaining mapping.
- R8: A cycle with `flush` high invalidates every entry. Lookups in the following cycles miss until refilled. A walker response arriving in the flush cycle is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Buffer accepts lookups (low while refilling) |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| rsp_hit | output | 1 | Translation valid this cycle |
| rsp_fault | output | 1 | Matching entry forbids this access |
| rsp_paddr | output | PA_W | Translated physical address (zero unless hit) |
| walk_req_valid | output | 1 | Refill request to table walker |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | VA_W-12 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker returns a mapping (one cycle) |
| walk_rsp_ppn | input | PA_W-12 | Returned physical page number |
| walk_rsp_perm | input | 2 | Returned permissions: bit 0 write, bit 1 user |

## Verification
The bench runs a small buffer through a full fill with distinct pages, then replays each page at the lowest, highest and a middle offset. This separates correct page matching and offset pass-through from mistakes in the offset or the stored page. It then overfills the buffer and probes pages in a set order: which pages still hit and which miss shows whether the victim pointer follows installation order. A sweep over all four permission codes and all four access kinds tells apart write and user checks, both on the first access through refill and on later hits. Probes after a flush show that every entry was cleared.

// File: rtl/tlb_pkg.sv
// Shared types for the translation buffer.
// Assumes: permission is two bits, bit 0 = write allowed, bit 1 = user allowed.
package tlb_pkg;

    typedef struct packed {
        logic usr_ok;
        logic wr_ok;
    } perm_t;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_REQ  = 2'd1,
        WK_WAIT = 2'd2
    } walk_st_e;

    // True when the access kind is not permitted by the entry.
    function automatic logic perm_denied(input perm_t p, input logic wr, input logic usr);
        return (wr & ~p.wr_ok) | (usr & ~p.usr_ok);
    endfunction

endpackage

// File: rtl/tlb_cam.sv
// Entry storage with parallel page-number compare.
// Does: holds ENTRIES mappings, compares the lookup page against all of them
//       at once and returns the matching entry's page and permission.
// Assumes: at most one entry matches (refills only happen on a miss);
//          flush has priority over a write in the same cycle.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  perm_t              wr_perm,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               match_any,
    output logic [PPN_W-1:0]   match_ppn,
    output perm_t              match_perm,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
    perm_t              ent_perm [ENTRIES];
    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] match_vec;

    // Valid bits: cleared by reset or flush, set by a refill write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_valid[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: written on refill, no reset needed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && !flush && wr_idx == IDX_W'(i)) begin
                ent_vpn[i]  <= wr_vpn;
                ent_ppn[i]  <= wr_ppn;
                ent_perm[i] <= wr_perm;
            end
        end
    end

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
    end

    // OR-mux of the (one-hot) matching entry.
    always_comb begin
        match_ppn  = '0;
        match_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                match_ppn  = match_ppn | ent_ppn[i];
                match_perm = match_perm | ent_perm[i];
            end
        end
    end

    assign match_any = |match_vec;
    assign valid_vec = ent_valid;

endmodule

// File: rtl/tlb_victim.sv
// Victim selection for refills.
// Does: picks the lowest-numbered invalid entry if any, else the entry under a
//       round-robin pointer; the pointer moves to the slot after each victim used.
// Assumes: advance is high for exactly the cycle a refill is written.
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Lowest-index invalid entry (scan from top so the lowest wins).
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    assign victim_idx = free_any ? free_idx : rr_ptr;

    // Round-robin pointer: slot after the victim just filled, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (advance) begin
            rr_ptr <= (victim_idx == IDX_W'(ENTRIES - 1)) ? '0 : victim_idx + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_walk_fsm.sv
// Refill sequencer towards the external table walker.
// Does: on a miss, captures the page number, issues a valid/ready request,
//       waits for the one-cycle response and signals the install.
// Assumes: the walker answers each accepted request exactly once.
module tlb_walk_fsm
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             miss,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output logic             busy,
    output logic             req_valid,
    output logic [VPN_W-1:0] req_vpn,
    output logic             install
);

    walk_st_e         state;
    logic [VPN_W-1:0] vpn_q;

    // State sequence: idle -> request -> wait for response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
            vpn_q <= '0;
        end else begin
            unique case (state)
                WK_IDLE: if (miss) begin
                    state <= WK_REQ;
                    vpn_q <= miss_vpn;
                end
                WK_REQ:  if (req_ready) state <= WK_WAIT;
                WK_WAIT: if (rsp_valid) state <= WK_IDLE;
                default: state <= WK_IDLE;
            endcase
        end
    end

    assign busy      = (state != WK_IDLE);
    assign req_valid = (state == WK_REQ);
    assign req_vpn   = vpn_q;
    assign install   = (state == WK_WAIT) && rsp_valid && !flush;

endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation buffer, top level.
// Does: translates page numbers in the lookup cycle, checks permissions,
//       refills misses from an external walker, flushes on request.
// Assumes: the requester holds lk_vaddr/lk_write/lk_user stable while
//          lk_valid is high and lk_ready is low.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 32,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    output logic             lk_ready,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             walk_req_valid,
    input  logic             walk_req_ready,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PPN_W-1:0] walk_rsp_ppn,
    input  logic [1:0]       walk_rsp_perm
);

    logic               busy;
    logic               accept;
    logic               match_any;
    logic [PPN_W-1:0]   match_ppn;
    perm_t              match_perm;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               install;
    logic               denied;
    logic [VPN_W-1:0]   lk_vpn;

    assign lk_vpn   = lk_vaddr[VA_W-1:PAGE_BITS];
    assign lk_ready = !busy;
    assign accept   = lk_valid && lk_ready;
    assign denied   = perm_denied(match_perm, lk_write, lk_user);

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .wr_en      (install),
        .wr_idx     (victim_idx),
        .wr_vpn     (walk_req_vpn),
        .wr_ppn     (walk_rsp_ppn),
        .wr_perm    (perm_t'(walk_rsp_perm)),
        .lk_vpn     (lk_vpn),
        .match_any  (match_any),
        .match_ppn  (match_ppn),
        .match_perm (match_perm),
        .valid_vec  (valid_vec)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .advance    (install),
        .victim_idx (victim_idx)
    );

    tlb_walk_fsm #(
        .VPN_W (VPN_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .miss      (accept && !match_any),
        .miss_vpn  (lk_vpn),
        .req_ready (walk_req_ready),
        .rsp_valid (walk_rsp_valid),
        .busy      (busy),
        .req_valid (walk_req_valid),
        .req_vpn   (walk_req_vpn),
        .install   (install)
    );

    // Response: hit with translated address, or fault on permission failure.
    always_comb begin
        rsp_hit   = accept && match_any && !denied;
        rsp_fault = accept && match_any && denied;
        rsp_paddr = rsp_hit ? {match_ppn, lk_vaddr[PAGE_BITS-1:0]} : '0;
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
// Protocol and response checker for tlb_xlate, attached with bind.
// Assumes: observes top-level ports only.
module tlb_xlate_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic                  lk_valid,
    input logic                  lk_ready,
    input logic [VA_W-1:0]       lk_vaddr,
    input logic                  rsp_hit,
    input logic                  rsp_fault,
    input logic [PA_W-1:0]       rsp_paddr,
    input logic                  walk_req_valid,
    input logic                  walk_req_ready,
    input logic [VA_W-PAGE_BITS-1:0] walk_req_vpn,
    input logic                  walk_rsp_valid
);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

    p_miss_walks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready && !rsp_hit && !rsp_fault |=> walk_req_valid && !lk_ready);

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_req_vpn));

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !lk_ready);

    p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready && !walk_req_valid && walk_rsp_valid |=> lk_ready);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    p_no_walk_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit || rsp_fault |=> !walk_req_valid);

    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rsp_hit && !rsp_fault);

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .lk_valid       (lk_valid),
    .lk_ready       (lk_ready),
    .lk_vaddr       (lk_vaddr),
    .rsp_hit        (rsp_hit),
    .rsp_fault      (rsp_fault),
    .rsp_paddr      (rsp_paddr),
    .walk_req_valid (walk_req_valid),
    .walk_req_ready (walk_req_ready),
    .walk_req_vpn   (walk_req_vpn),
    .walk_rsp_valid (walk_rsp_valid)
);

// File: tb/tb_tlb_xlate.sv
// Self-checking bench: small buffer, behavioural walker, arithmetic expectations.
module tb_tlb_xlate;

    localparam int N     = 8;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int PB    = 12;
    localparam int VPN_W = VA_W - PB;
    localparam int PPN_W = PA_W - PB;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             lk_valid = 1'b0;
    logic             lk_ready;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             lk_write = 1'b0;
    logic             lk_user = 1'b0;
    logic             rsp_hit;
    logic             rsp_fault;
    logic [PA_W-1:0]  rsp_paddr;
    logic             walk_req_valid;
    logic             walk_req_ready = 1'b0;
    logic [VPN_W-1:0] walk_req_vpn;
    logic             walk_rsp_valid = 1'b0;
    logic [PPN_W-1:0] walk_rsp_ppn = '0;
    logic [1:0]       walk_rsp_perm = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    tlb_xlate #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PB)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
        .walk_req_vpn(walk_req_vpn), .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_perm(walk_rsp_perm)
    );

    // Page mapping the walker returns.
    function automatic logic [PPN_W-1:0] map_ppn(input logic [VPN_W-1:0] v);
        return v ^ 20'h3A5C7;
    endfunction

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural walker: ready after 2 idle cycles, answer 2 cycles later.
    int          wk_dly = 0;
    int          wk_cnt = 0;
    logic        wk_acc = 1'b0;
    logic [VPN_W-1:0] wk_vpn = '0;
    always @(negedge clk) begin
        walk_rsp_valid = 1'b0;
        if (wk_acc) begin
            wk_acc = 1'b0;
            walk_req_ready = 1'b0;
            wk_cnt = 2;
        end
        if (wk_cnt > 0) begin
            wk_cnt--;
            if (wk_cnt == 0) begin
                walk_rsp_valid = 1'b1;
                walk_rsp_ppn   = map_ppn(wk_vpn);
                walk_rsp_perm  = wk_vpn[1:0];
            end
        end else if (walk_req_valid && !walk_req_ready) begin
            if (wk_dly == 2) begin
                walk_req_ready = 1'b1;
                wk_vpn = walk_req_vpn;
                wk_acc = 1'b1;
                wk_dly = 0;
            end else begin
                wk_dly++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // One lookup; reports whether it resolved without refill and the final result.
    task automatic access(input logic [VPN_W-1:0] vpn, input logic [PB-1:0] off,
                          input logic wr, input logic usr,
                          output logic first, output logic hit, output logic flt,
                          output logic [PA_W-1:0] pa);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_write = wr;
        lk_user  = usr;
        #1;
        first = rsp_hit || rsp_fault;
        if (!first) begin
            @(negedge clk); #1;
            check("R3 request raised", !lk_ready && walk_req_valid && walk_req_vpn == vpn,
                  longint'(walk_req_vpn), longint'(vpn));
            @(negedge clk); #1;
            check("R3 request held", walk_req_valid && walk_req_vpn == vpn,
                  longint'(walk_req_valid), 1);
            for (int k = 0; k < 40 && !lk_ready; k++) begin
                @(negedge clk); #1;
            end
            check("R4 ready after refill", lk_ready, longint'(lk_ready), 1);
        end
        hit = rsp_hit;
        flt = rsp_fault;
        pa  = rsp_paddr;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    // Access expecting a full read translation of a fully permitted page.
    task automatic probe(input string req, input logic [VPN_W-1:0] vpn,
                         input logic [PB-1:0] off, input logic exp_first);
        logic f, h, x;
        logic [PA_W-1:0] pa;
        access(vpn, off, 1'b0, 1'b0, f, h, x, pa);
        check(req, f == exp_first, longint'(f), longint'(exp_first));
        check("R2 translated address", h && !x && pa == {map_ppn(vpn), off},
              longint'(pa), longint'({map_ppn(vpn), off}));
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic logic [VPN_W-1:0] pg(input int i);
        return VPN_W'(16 * i + 3);
    endfunction

    initial begin
        logic f, h, x;
        logic [PA_W-1:0] pa;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check("R1 ready after reset", lk_ready && !walk_req_valid, longint'(lk_ready), 1);

        // R1/R7: empty buffer misses; fill all N entries.
        for (int i = 0; i < N; i++) probe("R7 fill miss", pg(i), 12'h123, 1'b0);

        // R2/R7: all N pages coexist; sweep offsets.
        for (int i = 0; i < N; i++) begin
            probe("R7 all resident", pg(i), 12'h000, 1'b1);
            probe("R2 offset high", pg(i), 12'hFFF, 1'b1);
            probe("R2 offset mid", pg(i), 12'h5A5, 1'b1);
        end

        // R7: overflow evicts oldest (page 0), then page 1, in order.
        probe("R7 new page miss", pg(N), 12'h010, 1'b0);
        for (int i = 1; i <= N; i++) probe("R7 survivors hit", pg(i), 12'h020, 1'b1);
        probe("R7 oldest evicted", pg(0), 12'h030, 1'b0);
        probe("R7 next oldest evicted", pg(1), 12'h040, 1'b0);
        probe("R7 newer kept", pg(3), 12'h050, 1'b1);
        probe("R7 refilled page kept", pg(0), 12'h060, 1'b1);

        // R8: after flush every previous page misses.
        do_flush();
        for (int i = 2; i < N; i++) probe("R8 miss after flush", pg(i), 12'h070, 1'b0);

        // R5/R6: every permission code against every access kind.
        do_flush();
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 4; a++) begin
                logic [VPN_W-1:0] v;
                logic wr, usr, exp_f;
                v   = VPN_W'(32'h200 + p);
                wr  = a[0];
                usr = a[1];
                exp_f = (wr && !p[0]) || (usr && !p[1]);
                access(v, 12'h0AB, wr, usr, f, h, x, pa);
                check("R5 fault decision", x == exp_f, longint'(x), longint'(exp_f));
                check("R6 hit xor fault", h == !exp_f && !(h && x), longint'(h), longint'(!exp_f));
                check("R5 refill only once", f == (a != 0), longint'(f), longint'(a != 0));
            end
        end

        // R6: a faulting lookup leaves no walk pending.
        access(VPN_W'(32'h200), 12'h001, 1'b1, 1'b1, f, h, x, pa);
        @(negedge clk); #1;
        check("R6 fault starts no walk", f && x && lk_ready && !walk_req_valid,
              longint'(walk_req_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule